// File: doc/BRIEF.md
# Smartcard Transmit-Side Error Signal Detector

This block sits beside the transmitter of a half-duplex, single-wire smartcard character link. When the transmitter sends the falling edge of a character's start bit, it pulses a start marker. The block then times the character in oversampled ticks. A card that finds a parity error pulls the shared line low at about ten and a half bit times. The block samples the line at exactly 11.0 bit times after the start edge. A low level at that point is recorded as a negative acknowledge (NACK).

From the start marker until the character is finished, the block raises a guard output. The receiver uses it to suppress start-bit detection. A falling edge from the card's error signal, which can arrive as late as 10.68 bit times or later, is therefore never taken as a new incoming character. When no error signal is seen, the character closes at 12 bit times. When one is seen, the character closes at 12 bit times or, if later, as soon as the line is back high. A one-cycle done pulse marks the close. The NACK flag carries the result and holds it until the next character starts.

The bit time is 16 ticks. Each tick lasts a programmable number of clock cycles. That divider value is captured only at the start marker.

Top module: `sc_nack_detector`

## Requirements
- R1: While reset is asserted, guard, done and NACK outputs are all low.
- R2: A start marker accepted while idle raises the guard on the next clock edge and clears the NACK flag on that same edge.
- R3: With D clock cycles per tick, the line level seen on the clock edge 176*D cycles after the accepted start edge decides the NACK flag. A low level sets it to 1 and a high level leaves it at 0. The flag is visible after that edge.
- R4: A low level on the line at any edge other than the sampling edge does not set the NACK flag.
- R5: When no NACK was sampled, the done pulse occurs and the guard falls on the edge 192*D cycles after the start edge, whatever the line level is then.
- R6: When a NACK was sampled and the line is high on the edge 192*D cycles after the start, the done pulse occurs and the guard falls on that edge.
- R7: When a NACK was sampled and the line is still low at 192*D cycles, the guard stays high until the first later edge on which the line is high. The done pulse occurs and the guard falls on that edge.
- R8: The done pulse lasts exactly one cycle per character. The NACK flag keeps its value after done until the next accepted start marker.
- R9: D equals the divider input captured on the start edge, with 0 treated as 1. Changes of the divider input during a character do not alter its timing.
- R10: A start marker that arrives while the guard is high is ignored and does not change that character's timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronized level of the shared data line |
| char_start_i | input | 1 | Pulse marking the start-bit falling edge of a transmitted character |
| etu_div_i | input | DIV_W | Clock cycles per oversample tick (0 treated as 1) |
| guard_o | output | 1 | High while receiver start-bit detection must be masked |
| done_o | output | 1 | One-cycle pulse when the character window closes |
| nack_o | output | 1 | Result of the last sampled character: 1 when a NACK was seen |

## Verification
A wrong tick or position count shifts the sampling edge or the close edge by whole multiples of D cycles. Such a fault shows on guard_o and done_o at the very character where it occurs. A sampling decision taken from the wrong edge shows on nack_o one cycle after the 176*D point. It shows first in cases where the line is low next to, but not on, that edge. A divider that is not frozen, or a phase machine that accepts a second start marker, moves the close edge of that same character.

// File: rtl/sc_nack_pkg.sv
package sc_nack_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   nack;
        logic   done;
    } ctl_t;

endpackage

// File: rtl/sc_nack_tick.sv
module sc_nack_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        div_eff = (st_q.div == '0) ? DIV_W'(1) : st_q.div;
        tick_o  = run_i && (st_q.cnt == div_eff - DIV_W'(1));
        st_d    = st_q;
        if (!run_i) begin
            st_d.div = div_i;
            st_d.cnt = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sc_nack_pos.sv
module sc_nack_pos #(
    parameter int SAMPLE_IDX  = 176,
    parameter int RELEASE_IDX = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic at_sample_o,
    output logic at_release_o
);
    localparam int IDX_W = $clog2(RELEASE_IDX + 1);
    localparam logic [IDX_W-1:0] SAMPLE_M1  = IDX_W'(SAMPLE_IDX - 1);
    localparam logic [IDX_W-1:0] RELEASE_M1 = IDX_W'(RELEASE_IDX - 1);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(RELEASE_IDX);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        at_sample_o  = tick_i && (idx_q == SAMPLE_M1);
        at_release_o = tick_i && (idx_q == RELEASE_M1);
        idx_d        = idx_q;
        if (!run_i)                           idx_d = '0;
        else if (tick_i && idx_q != LAST_IDX) idx_d = idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end
endmodule

// File: rtl/sc_nack_detector.sv
module sc_nack_detector #(
    parameter int DIV_W       = 8,
    parameter int OSR         = 16,
    parameter int SAMPLE_ETU  = 11,
    parameter int RELEASE_ETU = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             char_start_i,
    input  logic [DIV_W-1:0] etu_div_i,
    output logic             guard_o,
    output logic             done_o,
    output logic             nack_o
);
    import sc_nack_pkg::*;

    localparam int SAMPLE_IDX  = OSR * SAMPLE_ETU;
    localparam int RELEASE_IDX = OSR * RELEASE_ETU;

    ctl_t ctl_d, ctl_q;
    logic run, tick, at_sample, at_release;

    assign run = (ctl_q.phase != PH_IDLE);

    sc_nack_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (etu_div_i),
        .tick_o (tick)
    );

    sc_nack_pos #(.SAMPLE_IDX(SAMPLE_IDX), .RELEASE_IDX(RELEASE_IDX)) u_pos (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .tick_i       (tick),
        .at_sample_o  (at_sample),
        .at_release_o (at_release)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (char_start_i) begin
                    ctl_d.phase = PH_RUN;
                    ctl_d.nack  = 1'b0;
                end
            end
            PH_RUN: begin
                if (at_sample) ctl_d.nack = ~line_i;
                if (at_release) begin
                    if (ctl_q.nack && !line_i) begin
                        ctl_d.phase = PH_HOLD;
                    end else begin
                        ctl_d.phase = PH_IDLE;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (line_i) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_IDLE, nack: 1'b0, done: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign guard_o = run;
    assign done_o  = ctl_q.done;
    assign nack_o  = ctl_q.nack;
endmodule

// File: rtl/sc_nack_detector_chk.sv
module sc_nack_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic line_i,
    input logic char_start_i,
    input logic guard_o,
    input logic done_o,
    input logic nack_o
);
    assert_guard_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_o && char_start_i) |=> (guard_o && !nack_o));

    assert_done_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(guard_o) |-> done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !guard_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_nack_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_o && !char_start_i) |=> $stable(nack_o));

    assert_nack_from_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_o) |-> !$past(line_i));

    assert_hold_until_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && nack_o) |-> $past(line_i));
endmodule

bind sc_nack_detector sc_nack_detector_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_i),
    .char_start_i (char_start_i),
    .guard_o      (guard_o),
    .done_o       (done_o),
    .nack_o       (nack_o)
);

// File: tb/sc_nack_detector_test.sv
`timescale 1ns/1ps
module sc_nack_detector_test;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_i = 1'b1;
    logic             char_start_i = 1'b0;
    logic [DIV_W-1:0] etu_div_i = '0;
    logic             guard_o, done_o, nack_o;

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 1'b0;
    int unsigned seed_v;

    always #2.5 clk = ~clk;

    sc_nack_detector #(.DIV_W(DIV_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .char_start_i (char_start_i),
        .etu_div_i    (etu_div_i),
        .guard_o      (guard_o),
        .done_o       (done_o),
        .nack_o       (nack_o)
    );

    task automatic chk(input logic act, input logic exp, input string rq, input string nm);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", rq, nm, act, exp, $time);
        end
    endtask

    function automatic int eff_div(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic bit line_at(input int k, input int lo_a, input int lo_b);
        return !(k >= lo_a && k < lo_b);
    endfunction

    function automatic int close_edge(input int d, input int lo_a, input int lo_b);
        int s  = 176 * eff_div(d);
        int rl = 192 * eff_div(d);
        if (line_at(s, lo_a, lo_b)) return rl;
        return (lo_b <= rl) ? rl : lo_b;
    endfunction

    task automatic run_char(input int d, input int lo_a, input int lo_b,
                            input bit extra_start, input string tt, input string tn);
        int  s   = 176 * eff_div(d);
        int  ed  = close_edge(d, lo_a, lo_b);
        bit  nx  = !line_at(s, lo_a, lo_b);
        string tg, ng;
        for (int k = 0; k <= ed + 2; k++) begin
            @(negedge clk);
            char_start_i = (k == 0) || (extra_start && k == ed / 2);
            line_i       = line_at(k, lo_a, lo_b);
            etu_div_i    = (k == 0) ? DIV_W'(d) : DIV_W'($urandom % 8);
            @(posedge clk);
            #1;
            tg = (k == 0) ? "R2" : (k > ed) ? "R8" : tt;
            ng = (k == 0) ? "R2" : (k > ed) ? "R8" : tn;
            chk(guard_o, k < ed, tg, "guard");
            chk(done_o, k == ed, tg, "done");
            chk(nack_o, (k >= s) ? nx : 1'b0, ng, "nack");
        end
        @(negedge clk);
        char_start_i = 1'b0;
        line_i       = 1'b1;
        repeat ($urandom % 4) begin
            etu_div_i = DIV_W'($urandom % 8);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        seed_v = $urandom(32'h5EED1234);
        repeat (4) @(posedge clk);
        #1;
        chk(guard_o, 1'b0, "R1", "guard");
        chk(done_o, 1'b0, "R1", "done");
        chk(nack_o, 1'b0, "R1", "nack");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        run_char(1, 0, 0, 1'b0, "R5", "R3");           // no error signal
        run_char(1, 168, 184, 1'b0, "R6", "R3");       // NACK ends before 12 etu
        run_char(2, 336, 424, 1'b0, "R7", "R3");       // NACK held past 12 etu
        run_char(1, 175, 176, 1'b0, "R5", "R4");       // low only one edge early
        run_char(1, 177, 181, 1'b0, "R5", "R4");       // low only after sample edge
        run_char(3, 510, 543, 1'b1, "R10", "R3");      // second start marker ignored
        run_char(0, 170, 200, 1'b0, "R9", "R3");       // divider 0 acts as 1
        run_char(4, 0, 0, 1'b0, "R9", "R3");           // divider changes mid-character
        run_char(2, 300, 352, 1'b0, "R6", "R3");       // line back high exactly at sample edge

        // constrained random characters
        for (int n = 0; n < 30; n++) begin
            int d    = $urandom % 4;
            int de   = eff_div(d);
            int mode = $urandom % 4;
            int a, b;
            case (mode)
                0: begin a = 0; b = 0; end
                1: begin a = 168 * de + int'($urandom % (4 * de + 1)); b = a + 16 * de; end
                2: begin a = 168 * de + int'($urandom % (4 * de + 1)); b = 192 * de + 1 + int'($urandom % 30); end
                default: begin a = 170 * de + int'($urandom % (12 * de)); b = a + 1 + int'($urandom % 3); end
            endcase
            run_char(d, a, b, ($urandom % 4) == 0,
                     (mode == 0) ? "R5" : (mode == 1) ? "R6" : (mode == 2) ? "R7" : "R4",
                     (mode == 3) ? "R4" : "R3");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule